// File: doc/BRIEF.md
# Synchronous Serial Slave Engine with Underflow Hold

This block is the slave side of a four-wire synchronous serial link. An external master supplies the serial clock and the select line. The block takes its incoming bits from MOSI and drives MISO from a small transmit queue. For each frame the master clocks, one frame moves in each direction. The slave never starts a transfer. A word that software writes into the transmit queue waits there until the master selects the slave and clocks the frame.

When the master clocks a frame and no word is queued, the block raises a sticky underflow flag. MISO then repeats the last bit it sent, so it does not fall back to a fixed idle level. The select line can come from a pin, or it can come from an internal polarity control when the pin is disabled. Only one clocking mode is supported: SCLK idles low, MOSI is sampled on the rising edge, and MISO changes on the falling edge. SCLK, MOSI and the select pin each pass through a two-flop synchronizer. The system clock must run at least four times faster than SCLK.

The engine is a four-state machine:

- **IDLE**: the slave is not selected.
- **ARM**: loads the next outgoing word, or the hold pattern, before the first rising edge.
- **SHIFT**: shifts bits in and out until the frame is complete.
- **TAIL**: waits for the falling edge after the last bit.

The transitions are:

- IDLE→ARM when select becomes active.
- ARM→SHIFT unconditionally after one cycle.
- SHIFT→TAIL on the last rising edge of a frame.
- TAIL→ARM on the next falling edge.
- Any state→IDLE as soon as select drops.

Top module: `sspi_slave`

## Requirements
- R1: After reset, miso_o is 0, rx_valid is 0, tx_full is 0, and both flags are 0.
- R2: The eight MOSI bits of a frame are assembled MSB first, sampled on rising SCLK edges. The result appears at rx_rdata with rx_valid=1 once the eighth rising edge has been seen.
- R3: Each frame shifts out one queued transmit word, MSB first, in write order. The first bit is on MISO before the first rising edge, and later bits change on falling edges. A word leaves the queue at the first rising edge of its frame.
- R4: While select is inactive, SCLK activity transfers nothing. The queue is unchanged, no word is received, and MISO is unchanged.
- R5: Between frames and after select is released, MISO holds the last bit sent. A frame clocked with no word loaded sends that bit in all eight positions.
- R6: If tx_en=1 and no word was loaded when the first rising edge of a frame arrives, txuf_flag is set. With tx_en=0, the frame sends the hold level, txuf_flag is not set, and queued words stay queued.
- R7: With cs_pin_en=0, the slave is selected when cs_inv=0 and deselected when cs_inv=1. The cs_i pin is ignored.
- R8: With cs_pin_en=1, the slave is selected when the level of cs_i equals cs_inv. cs_inv=0 gives active-low select, and cs_inv=1 gives active-high select.
- R9: If select drops in the middle of a frame, the partial frame is discarded. The next frame is received in full.
- R10: A frame completed while the receive queue (depth 2) is full is dropped and sets rxof_flag. The words already held are kept.
- R11: tx_full is 1 when the transmit queue (depth 2) is full, and writes made while it is full are ignored.
- R12: flag_clr clears both flags. If a flag is set in the same cycle as flag_clr, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Master-to-slave data |
| cs_i | input | 1 | Select pin |
| miso_o | output | 1 | Slave-to-master data |
| cs_pin_en | input | 1 | 1: select comes from cs_i; 0: select comes from cs_inv |
| cs_inv | input | 1 | Select polarity / internal select control |
| tx_en | input | 1 | Transmitter enable |
| tx_wr | input | 1 | Write strobe into the transmit queue |
| tx_wdata | input | FRAME_W | Word to transmit |
| tx_full | output | 1 | Transmit queue is full |
| rx_rd | input | 1 | Pops the head of the receive queue |
| rx_rdata | output | FRAME_W | Head of the receive queue |
| rx_valid | output | 1 | Receive queue is not empty |
| flag_clr | input | 1 | Clears the sticky flags |
| txuf_flag | output | 1 | Sticky transmit underflow flag |
| rxof_flag | output | 1 | Sticky receive overflow flag |

## Verification
The assertions check on every cycle that:

- MISO does not move while the slave is deselected.
- The bit counter returns to zero whenever select drops.
- A word leaves the transmit queue only at the first bit of a frame.
- An underflow frame keeps the MISO level.
- A full queue ignores a write.

Only the bench's scenarios can show the end-to-end results:

- The actual bit order and data on both lines.
- That a queued word waits through SCLK activity while the slave is deselected.
- The hold pattern that follows a particular last bit.
- The select decoding for each combination of pin enable and polarity.
- Recovery after an aborted frame.

// File: rtl/sspi_pkg.sv
package sspi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } eng_state_e;
endpackage

// File: rtl/sspi_sync.sv
module sspi_sync #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[g];
                s2_q <= RST_VAL[g];
            end else begin
                s1_q <= d_i[g];
                s2_q <= s1_q;
            end
        end
        assign q_o[g] = s2_q;
    end
endmodule

// File: rtl/sspi_fifo.sv
module sspi_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] count_q;
    logic          do_wr, do_rd;

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CW'(DEPTH));
    assign do_wr   = wr_en && !full_o;
    assign do_rd   = rd_en && !empty_o;
    assign rd_data = mem_q[rptr_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[wptr_q] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (do_wr) wptr_q <= bump(wptr_q);
            if (do_rd) rptr_q <= bump(rptr_q);
            if (do_wr && !do_rd)      count_q <= count_q + CW'(1);
            else if (do_rd && !do_wr) count_q <= count_q - CW'(1);
        end
    end

    // R10 R11
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full_o && !rd_en) |=> $stable(count_q));
endmodule

// File: rtl/sspi_engine.sv
module sspi_engine
    import sspi_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               mosi_bit,
    input  logic               tx_en,
    input  logic               txq_empty,
    input  logic [FRAME_W-1:0] txq_data,
    output logic               txq_pop,
    input  logic               rxq_full,
    output logic               rxq_push,
    output logic [FRAME_W-1:0] rxq_data,
    output logic               miso,
    output logic               txuf_set,
    output logic               rxof_set
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    eng_state_e         state_q, state_d;
    logic [CNT_W-1:0]   bitcnt_q;
    logic [FRAME_W-1:0] shreg_q, rxsh_q;
    logic               miso_q, have_q;
    logic               frame_last, first_rise;

    assign frame_last = sclk_rise && (bitcnt_q == CNT_W'(FRAME_W - 1));
    assign first_rise = sclk_rise && (bitcnt_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sel) state_d = ST_ARM;
            ST_ARM:   state_d = ST_SHIFT;
            ST_SHIFT: if (frame_last) state_d = ST_TAIL;
            ST_TAIL:  if (sclk_fall) state_d = ST_ARM;
            default:  state_d = ST_IDLE;
        endcase
        if (!sel) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        txq_pop  = 1'b0;
        txuf_set = 1'b0;
        rxq_push = 1'b0;
        rxof_set = 1'b0;
        if (sel && state_q == ST_SHIFT) begin
            txq_pop  = first_rise && have_q;
            txuf_set = first_rise && !have_q && tx_en;
            rxq_push = frame_last && !rxq_full;
            rxof_set = frame_last && rxq_full;
        end
    end
    assign rxq_data = {rxsh_q[FRAME_W-2:0], mosi_bit};
    assign miso     = miso_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            rxsh_q   <= '0;
            miso_q   <= 1'b0;
            have_q   <= 1'b0;
        end else if (!sel) begin
            bitcnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_ARM: begin
                    bitcnt_q <= '0;
                    if (tx_en && !txq_empty) begin
                        shreg_q <= txq_data;
                        miso_q  <= txq_data[FRAME_W-1];
                        have_q  <= 1'b1;
                    end else begin
                        shreg_q <= {FRAME_W{miso_q}};
                        have_q  <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (sclk_rise) begin
                        rxsh_q   <= {rxsh_q[FRAME_W-2:0], mosi_bit};
                        bitcnt_q <= frame_last ? '0 : bitcnt_q + CNT_W'(1);
                    end else if (sclk_fall && bitcnt_q != '0) begin
                        shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                        miso_q  <= shreg_q[FRAME_W-2];
                    end
                end
                default: ;
            endcase
        end
    end

    // R5
    miso_hold_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(miso_q));
    // R9
    abort_count_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> bitcnt_q == '0);
    // R3
    pop_at_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txq_pop |=> bitcnt_q == CNT_W'(1));
    // R6
    underflow_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txuf_set |=> $stable(miso_q));
    // R2
    push_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |=> (state_q == ST_TAIL || state_q == ST_IDLE));
endmodule

// File: rtl/sspi_slave.sv
module sspi_slave #(
    parameter int FRAME_W  = 8,
    parameter int TX_DEPTH = 2,
    parameter int RX_DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               mosi_i,
    input  logic               cs_i,
    output logic               miso_o,
    input  logic               cs_pin_en,
    input  logic               cs_inv,
    input  logic               tx_en,
    input  logic               tx_wr,
    input  logic [FRAME_W-1:0] tx_wdata,
    output logic               tx_full,
    input  logic               rx_rd,
    output logic [FRAME_W-1:0] rx_rdata,
    output logic               rx_valid,
    input  logic               flag_clr,
    output logic               txuf_flag,
    output logic               rxof_flag
);
    logic [2:0]         pins_s;
    logic               sclk_d_q, sel;
    logic               sclk_rise, sclk_fall;
    logic               txq_empty, txq_pop, rxq_full, rxq_push, rxq_empty;
    logic [FRAME_W-1:0] txq_data, rxq_data;
    logic               txuf_set, rxof_set, txuf_q, rxof_q;

    sspi_sync #(.N(3), .RST_VAL(3'b100)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .d_i({cs_i, mosi_i, sclk_i}), .q_o(pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d_q <= 1'b0;
        else        sclk_d_q <= pins_s[0];
    end
    assign sclk_rise = pins_s[0] && !sclk_d_q;
    assign sclk_fall = !pins_s[0] && sclk_d_q;
    assign sel       = ((cs_pin_en ? pins_s[2] : 1'b0) == cs_inv);

    sspi_fifo #(.W(FRAME_W), .DEPTH(TX_DEPTH)) txq_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tx_wr), .wr_data(tx_wdata),
        .rd_en(txq_pop), .rd_data(txq_data),
        .empty_o(txq_empty), .full_o(tx_full)
    );

    sspi_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) rxq_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rxq_push), .wr_data(rxq_data),
        .rd_en(rx_rd), .rd_data(rx_rdata),
        .empty_o(rxq_empty), .full_o(rxq_full)
    );
    assign rx_valid = !rxq_empty;

    sspi_engine #(.FRAME_W(FRAME_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_bit(pins_s[1]),
        .tx_en(tx_en), .txq_empty(txq_empty), .txq_data(txq_data), .txq_pop(txq_pop),
        .rxq_full(rxq_full), .rxq_push(rxq_push), .rxq_data(rxq_data),
        .miso(miso_o), .txuf_set(txuf_set), .rxof_set(rxof_set)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txuf_q <= 1'b0;
            rxof_q <= 1'b0;
        end else begin
            txuf_q <= (txuf_q && !flag_clr) || txuf_set;
            rxof_q <= (rxof_q && !flag_clr) || rxof_set;
        end
    end
    assign txuf_flag = txuf_q;
    assign rxof_flag = rxof_q;

    // R12
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txuf_set || rxof_set) |=> (txuf_q || rxof_q));
endmodule

// File: tb/sspi_slave_tb_top.sv
module sspi_slave_tb_top;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_i = 1'b0, mosi_i = 1'b0, cs_i = 1'b1;
    logic       cs_pin_en = 1'b1, cs_inv = 1'b0, tx_en = 1'b1;
    logic       tx_wr = 1'b0, rx_rd = 1'b0, flag_clr = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       miso_o, tx_full, rx_valid, txuf_flag, rxof_flag;
    logic [7:0] rx_rdata;

    int         n_cmp = 0, n_bad = 0;
    bit         mon_en = 1'b1;
    bit         done = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    sspi_slave dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .mosi_i(mosi_i), .cs_i(cs_i),
        .miso_o(miso_o), .cs_pin_en(cs_pin_en), .cs_inv(cs_inv), .tx_en(tx_en),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full), .rx_rd(rx_rd),
        .rx_rdata(rx_rdata), .rx_valid(rx_valid), .flag_clr(flag_clr),
        .txuf_flag(txuf_flag), .rxof_flag(rxof_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops received words and compares against the scoreboard queue
    always @(negedge clk) begin
        if (rx_rd) rx_rd <= 1'b0;
        else if (mon_en && rx_valid) begin
            if (exp_q.size() == 0) check("R2 R4 unexpected rx", {24'd0, rx_rdata}, 32'hFFFF_FFFF);
            else check("R2 rx data", {24'd0, rx_rdata}, {24'd0, exp_q.pop_front()});
            rx_rd <= 1'b1;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_tx(input logic [7:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic clr_flags();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic cs_on();  cs_i = cs_inv; idle(2 * HALF); endtask
    task automatic cs_off(); cs_i = ~cs_inv; idle(2 * HALF); endtask

    // clocks nbits of mo; returns bits seen on MISO just before each rising edge
    task automatic clock_bits(input int nbits, input logic [7:0] mo, output logic [7:0] mi);
        mi = '0;
        for (int i = 0; i < nbits; i++) begin
            mosi_i = mo[7-i];
            idle(HALF);
            mi[7-i] = miso_o;
            sclk_i = 1'b1;
            idle(HALF);
            sclk_i = 1'b0;
        end
        idle(HALF);
    endtask

    task automatic frame(input logic [7:0] mo, input bit push_exp,
                         input bit chk_mi, input logic [7:0] exp_mi, input string req);
        logic [7:0] mi;
        if (push_exp) exp_q.push_back(mo);
        clock_bits(8, mo, mi);
        if (chk_mi) check(req, {24'd0, mi}, {24'd0, exp_mi});
    endtask

    task automatic drain(input string req);
        for (int t = 0; t < 200 && exp_q.size() != 0; t++) idle(1);
        idle(4);
        check(req, exp_q.size(), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] dummy;
        idle(5);
        rst_n = 1'b1;
        idle(2);
        // R1
        check("R1 miso", miso_o, 0);
        check("R1 rx_valid", rx_valid, 0);
        check("R1 tx_full", tx_full, 0);
        check("R1 flags", {txuf_flag, rxof_flag}, 0);

        // R4: queued data waits while deselected
        wr_tx(8'hA5);
        wr_tx(8'h3C);
        clock_bits(8, 8'hFF, dummy);
        idle(HALF);
        check("R4 no rx while deselected", rx_valid, 0);
        check("R4 miso unchanged", miso_o, 0);

        // R2 R3: two frames in write order
        cs_on();
        frame(8'h81, 1, 1, 8'hA5, "R3 first word");
        frame(8'h42, 1, 1, 8'h3C, "R3 second word order");
        cs_off();
        drain("R2 both frames received");
        check("R6 no underflow with data", txuf_flag, 0);
        check("R5 miso holds last bit 0", miso_o, 0);

        // R11: third write while full is ignored
        wr_tx(8'h0F);
        wr_tx(8'hF1);
        check("R11 tx_full", tx_full, 1);
        wr_tx(8'h77);
        cs_on();
        frame(8'h10, 1, 1, 8'h0F, "R11 word1");
        frame(8'h20, 1, 1, 8'hF1, "R11 word2");
        // R5 R6: underflow frame repeats last bit (1)
        frame(8'h30, 1, 1, 8'hFF, "R5 underflow hold pattern");
        cs_off();
        drain("R2 rx");
        check("R6 underflow flag", txuf_flag, 1);
        check("R5 miso holds 1 after release", miso_o, 1);
        // R12
        clr_flags();
        check("R12 flag cleared", txuf_flag, 0);

        // R6: tx_en=0 keeps data and sets no flag
        wr_tx(8'h55);
        tx_en = 1'b0;
        cs_on();
        frame(8'h5A, 1, 1, 8'hFF, "R6 disabled tx sends hold");
        cs_off();
        check("R6 no flag with tx_en=0", txuf_flag, 0);
        tx_en = 1'b1;
        cs_on();
        frame(8'hA6, 1, 1, 8'h55, "R6 data retained");
        cs_off();
        drain("R6 rx");

        // R9: aborted frame discarded
        wr_tx(8'hC3);
        cs_on();
        clock_bits(3, 8'hE0, dummy);
        cs_off();
        check("R9 partial not received", rx_valid, 0);
        cs_on();
        frame(8'h99, 1, 0, 8'h00, "R9");
        cs_off();
        drain("R9 full frame after abort");
        clr_flags();

        // R10: overflow drops third frame
        mon_en = 1'b0;
        cs_on();
        frame(8'hA1, 1, 0, 8'h00, "R10");
        frame(8'hB2, 1, 0, 8'h00, "R10");
        frame(8'hC4, 0, 0, 8'h00, "R10");
        cs_off();
        check("R10 overflow flag", rxof_flag, 1);
        mon_en = 1'b1;
        drain("R10 held words kept, extra dropped");
        clr_flags();
        check("R12 overflow cleared", rxof_flag, 0);

        // R7: internal select
        wr_tx(8'h6B);
        cs_pin_en = 1'b0;
        idle(2 * HALF);
        frame(8'h2D, 1, 1, 8'h6B, "R7 internal select active");
        idle(HALF);
        drain("R7 rx");
        cs_inv = 1'b1;
        idle(2 * HALF);
        wr_tx(8'hE0);
        clock_bits(8, 8'h77, dummy);
        idle(HALF);
        check("R7 deselected by cs_inv=1", rx_valid, 0);
        cs_inv = 1'b0;
        idle(2 * HALF);
        frame(8'h4E, 1, 1, 8'hE0, "R7 word waited");
        drain("R7 rx2");

        // R8: active-high pin select
        cs_i = 1'b0;
        cs_inv = 1'b1;
        cs_pin_en = 1'b1;
        idle(2 * HALF);
        wr_tx(8'h3A);
        check("R8 inactive with pin low", rx_valid, 0);
        cs_on();
        frame(8'h11, 1, 1, 8'h3A, "R8 active-high select");
        cs_off();
        drain("R8 rx");

        finish_run();
    end
endmodule